// File: doc/BRIEF.md
# Stretchable CPU Clock Generator

This block derives the CPU phase-2 clock from a master oscillator running at twice the CPU rate. It inserts wait-states for slow bus accesses by holding phase 2 high for extra master cycles. The CPU ready line is never used for waiting. A second clock, the global clock, runs at the same base rate and phase as an unstretched phase 2 but is never held. Peripherals that keep their own time, such as interval timers, can run from it and stay accurate while slow accesses are being stretched.

The block decodes a 24-bit bank/address bus. Any address in bank 0 at or above offset $C000 is a slow access. An exemption input tells the block that the selected device runs from the global clock, and that cycle is then not stretched. A static input selects how many wait-states a slow cycle receives: one or two.

Both clocks and a cycle-done strobe come straight from registers. The strobe lets a bench or a monitor count phase-2 cycles and measure how long each high phase lasted.

Top module: `clk_stretch_gen`

## Requirements
- R1: While `rst` is high at a master clock edge, `phi2`, `gclk` and `cyc_done` are all 0 after that edge, and no stretch is pending once reset is released.
- R2: When no stretch applies, `phi2` is high for exactly 1 master cycle and low for exactly 1 master cycle, giving a period of 2 master cycles.
- R3: `gclk` toggles on every master clock edge after reset, including during stretches. It reads 0 whenever `phi2` is in its low phase.
- R4: `wse_n` is 0 exactly when `addr[23:16]` equals 8'h00 and `addr[15:0]` is at least 16'hC000. Otherwise it is 1.
- R5: A slow cycle with `two_ws` = 0 and `exempt` = 0 keeps `phi2` high for 3 master cycles. That is the normal 1 plus one wait-state of 2.
- R6: A slow cycle with `two_ws` = 1 and `exempt` = 0 keeps `phi2` high for 5 master cycles. That is the normal 1 plus two wait-states of 2 each.
- R7: The low phase of `phi2` is always exactly 1 master cycle, whether or not the preceding high phase was stretched.
- R8: With `exempt` = 1, a slow address gives an unstretched 1-cycle high phase.
- R9: The wait request (`wse_n`, `exempt`) and `two_ws` are sampled only at the master edge that would normally end the high phase. Changing any of them before or after that edge does not alter the length of the current high phase.
- R10: `rdy` is held at 1 at all times.
- R11: `cyc_done` is 1 for exactly one master cycle after each falling edge of `phi2`, namely the low phase, and is 0 while `phi2` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master oscillator clock, twice the CPU rate |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | Bank byte in bits 23:16, offset in bits 15:0 |
| exempt | input | 1 | Selected device runs from the global clock; suppresses stretching |
| two_ws | input | 1 | 0: one wait-state per slow cycle, 1: two wait-states |
| phi2 | output | 1 | Stretchable CPU phase-2 clock |
| gclk | output | 1 | Free-running global clock, never stretched |
| wse_n | output | 1 | Active-low slow-access decode |
| rdy | output | 1 | CPU ready, held inactive (not waiting) |
| cyc_done | output | 1 | One-master-cycle strobe after each fall of `phi2` |

## Verification
The bench builds the block with its default parameters: a 24-bit bus, slow bank 0 and slow base $C000. It sweeps four bank values and all sixteen upper-offset nibbles, each with low offsets of all-zeros and all-ones, across every combination of `exempt` and `two_ws`. This reaches the $BFFF/$C000 boundary and the bank-0 edge. Each high phase and low phase is measured in master cycles against a length computed from the decode. Separate runs change the address and `two_ws` just before and just after the sampling edge. These runs show that only the value present at the sampling edge sets the stretch.

// File: rtl/clk_stretch_gen.sv
module clk_stretch_gen #(
  parameter int BANK_W = 8,
  parameter int OFFS_W = 16,
  parameter logic [BANK_W-1:0] SLOW_BANK = '0,
  parameter logic [OFFS_W-1:0] SLOW_BASE = 16'hC000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [BANK_W+OFFS_W-1:0] addr,
  input  logic                     exempt,
  input  logic                     two_ws,
  output logic                     phi2,
  output logic                     gclk,
  output logic                     wse_n,
  output logic                     rdy,
  output logic                     cyc_done
);
  localparam int WS_TICKS = 2;
  localparam int HOLD_W = $clog2(2 * WS_TICKS + 1);

  logic [HOLD_W-1:0] hold, hold_nxt;
  logic              phi2_nxt;
  logic              req;

  assign wse_n = !((addr[BANK_W+OFFS_W-1:OFFS_W] == SLOW_BANK) &&
                   (addr[OFFS_W-1:0] >= SLOW_BASE));
  assign req   = !wse_n && !exempt;
  assign rdy   = 1'b1;

  always_comb begin
    phi2_nxt = 1'b0;
    hold_nxt = '0;
    if (!phi2) begin
      phi2_nxt = 1'b1;
    end else if (hold == '0) begin
      if (req) begin
        phi2_nxt = 1'b1;
        hold_nxt = two_ws ? HOLD_W'(2 * WS_TICKS) : HOLD_W'(WS_TICKS);
      end
    end else begin
      hold_nxt = hold - 1'b1;
      phi2_nxt = (hold != HOLD_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phi2     <= 1'b0;
      gclk     <= 1'b0;
      hold     <= '0;
      cyc_done <= 1'b0;
    end else begin
      phi2     <= phi2_nxt;
      gclk     <= !gclk;
      hold     <= hold_nxt;
      cyc_done <= phi2 && !phi2_nxt;
    end
  end

  AST_LOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $fell(phi2) |=> phi2); // R7

  AST_GCLK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> gclk != $past(gclk)); // R3

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cyc_done == $fell(phi2)); // R11

  AST_NO_STRETCH_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
    phi2 && hold == '0 && !req |=> !phi2); // R8

  AST_STRETCH_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    phi2 && hold == '0 && req |=> phi2); // R5

  AST_HOLD_ONLY_HIGH: assert property (@(posedge clk) disable iff (rst)
    !phi2 |-> hold == '0); // R9

endmodule

// File: tb/tb_clk_stretch_gen.sv
module tb_clk_stretch_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] addr = '0;
  logic        exempt = 1'b0;
  logic        two_ws = 1'b0;
  logic        phi2, gclk, wse_n, rdy, cyc_done;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic gprev = 1'b0;
  logic armed = 1'b0;

  clk_stretch_gen dut (
    .clk(clk), .rst(rst), .addr(addr), .exempt(exempt), .two_ws(two_ws),
    .phi2(phi2), .gclk(gclk), .wse_n(wse_n), .rdy(rdy), .cyc_done(cyc_done)
  );

  always #10 clk = !clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      check(gclk != gprev, "R3 gclk toggle", gclk, !gprev);
      check(rdy == 1'b1, "R10 rdy", rdy, 1);
    end
    gprev = gclk;
    if (!rst) armed = 1'b1;
  end

  // Precondition: at a negedge with phi2 low. Returns at a negedge with phi2 low.
  task automatic measure(output int hi);
    hi = 0;
    @(negedge clk);
    while (phi2 && hi < 12) begin
      check(cyc_done == 1'b0, "R11 strobe low while high", cyc_done, 0);
      hi++;
      @(negedge clk);
    end
    check(hi >= 1, "R7 low phase one cycle", hi, 1);
    check(cyc_done == 1'b1, "R11 strobe after fall", cyc_done, 1);
    check(gclk == 1'b0, "R3 gclk phase", gclk, 0);
  endtask

  task automatic run_cycle(input int bank, input int nib, input int lo, input bit ex, input bit two);
    int hi, exp_hi;
    bit slow;
    addr = 24'(bank << 16) | 24'(nib << 12) | 24'(lo);
    exempt = ex;
    two_ws = two;
    #1;
    slow = (bank == 0) && (nib >= 12);
    check(wse_n == !slow, "R4 decode", wse_n, !slow);
    exp_hi = 1 + ((slow && !ex) ? (two ? 4 : 2) : 0);
    measure(hi);
    if (slow && ex) check(hi == exp_hi, "R8 exempt", hi, exp_hi);
    else if (!slow) check(hi == exp_hi, "R2 unstretched", hi, exp_hi);
    else if (two) check(hi == exp_hi, "R6 two waits", hi, exp_hi);
    else check(hi == exp_hi, "R5 one wait", hi, exp_hi);
  endtask

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    check(phi2 == 1'b0 && gclk == 1'b0 && cyc_done == 1'b0, "R1 reset state",
          {phi2, gclk, cyc_done}, 0);
    rst = 1'b0;

    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 16; n++)
        for (int l = 0; l < 2; l++)
          for (int e = 0; e < 2; e++)
            for (int t = 0; t < 2; t++)
              run_cycle((b == 0) ? 0 : (b == 1) ? 1 : (b == 2) ? 8'h80 : 8'hFF,
                        n, l ? 12'hFFF : 12'h000, e[0], t[0]);

    // R9: slow with two waits sampled, then bus goes fast and two_ws drops mid-stretch
    addr = 24'h00C123; exempt = 1'b0; two_ws = 1'b1;
    hi = 0;
    @(negedge clk); if (phi2) hi++;
    @(negedge clk); if (phi2) hi++;
    addr = 24'h001000; two_ws = 1'b0;
    while (phi2 && hi < 12) begin @(negedge clk); if (phi2) hi++; end
    check(hi == 5, "R9 late change ignored", hi, 5);

    // R9: fast at sample point, slow afterwards gives no stretch
    addr = 24'h002000;
    measure(hi);
    check(hi == 1, "R9 fast sample", hi, 1);
    addr = 24'h00F000;
    measure(hi);
    check(hi == 3, "R9 next cycle sees slow", hi, 3);

    // R9: exempt raised after sample point does not cut the stretch
    addr = 24'h00E000; exempt = 1'b0; two_ws = 1'b0;
    hi = 0;
    @(negedge clk); if (phi2) hi++;
    @(negedge clk); if (phi2) hi++;
    exempt = 1'b1;
    while (phi2 && hi < 12) begin @(negedge clk); if (phi2) hi++; end
    check(hi == 3, "R9 late exempt ignored", hi, 3);

    // R1: reset mid-stretch returns to phase 1 with nothing pending
    exempt = 1'b0; two_ws = 1'b1; addr = 24'h00FFFF;
    @(negedge clk); @(negedge clk);
    rst = 1'b1; armed = 1'b0;
    @(negedge clk); @(negedge clk);
    check(phi2 == 1'b0 && gclk == 1'b0 && cyc_done == 1'b0, "R1 reset mid-stretch",
          {phi2, gclk, cyc_done}, 0);
    addr = 24'h010000;
    rst = 1'b0;
    measure(hi);
    check(hi == 1, "R1 no pending stretch", hi, 1);

    finish_run();
  end
endmodule